// File: doc/BRIEF.md
# Peripheral-to-Pad Routing Crossbar

This block lets any one of 120 peripheral signals be placed on any pad of a 64-pad general-purpose bank. Each signal has a 7-bit select register. A select value k from 1 to 64 places the signal on bank pad k-1. The bank is the global pin range 8 to 71, so bank pad k-1 is global pin k+7: select 3 lands on pin 10 and select 20 on pin 27. The value 0 and every value from 65 to 127 leave the signal unrouted. The signal order is fixed. Indices 84 to 91 are the four I2C clock/data pairs. Indices 93, 97, 101 and 105 are the receive lines of the four routable UARTs.

The input direction is combinational from the select registers. Each peripheral input reads the bank pad its select names, and an unrouted input reads a fixed idle level. Pad drive needs a priority decision, so it comes from a pad ownership table. A small scanner rebuilds that table after any select write. The scanner states are IDLE, CLEAR, WALK and COMMIT. Its transitions are:
- IDLE to CLEAR on a select write.
- CLEAR to WALK.
- WALK stays in WALK while the index advances, and goes to COMMIT after the last signal.
- COMMIT to IDLE.
- Any select write in CLEAR, WALK or COMMIT goes to CLEAR.

WALK visits the signals from index 0 upward. The first signal to claim a pad owns it, and any later claim on the same pad sets a conflict. COMMIT copies the finished table to the live table in one step. A write of 1 in bit 0 to configuration address 120 clears the sticky conflict flag.

Top module: `pad_route_xbar`

## Requirements
- R1: After reset every select register is 0, every pad output enable and pad output is 0, and the conflict flag is 0.
- R2: A write with `cfg_we` high to an address below 120 loads `cfg_wdata` into that signal's select register on the clock edge. The peripheral input of that signal follows the new select from that edge on.
- R3: A select value k in 1..64 maps the signal to bank pad k-1, which is global pin k+7. Values 0 and 65..127 leave the signal unrouted in both directions.
- R4: A pad owned by signal i drives `pad_out` = `periph_out[i]` and `pad_oe` = `periph_oe[i]`. The live table reflects a select write within 123 clock edges of the edge that took the write, provided no further select write occurs.
- R5: A pad that no routed signal selects has `pad_oe` and `pad_out` at 0.
- R6: When several signals select the same pad, the one with the lowest index drives it.
- R7: A committed table that contains a shared pad sets `conflict_flag`, and the flag stays set. A write to address 120 with bit 0 set clears it; the same write with bit 0 clear leaves it unchanged.
- R8: Several signals may select the same pad, and each of their peripheral inputs receives that pad's value.
- R9: An unrouted peripheral input reads 1 for indices 84..91, 93, 97, 101 and 105, and 0 for all others.
- R10: The live ownership table changes only in COMMIT. A select write during a rebuild restarts it from CLEAR, and the previous live table stays in force until the restarted rebuild commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Signal index 0..119, or 120 for the flag clear |
| cfg_wdata | input | 7 | Select value, or bit 0 = clear flag at address 120 |
| periph_out | input | 120 | Output value of each peripheral signal |
| periph_oe | input | 120 | Output enable of each peripheral signal |
| periph_in | output | 120 | Value returned to each peripheral input |
| pad_in | input | 64 | Value read from each bank pad |
| pad_out | output | 64 | Value driven to each bank pad |
| pad_oe | output | 64 | Output enable of each bank pad |
| conflict_flag | output | 1 | Sticky flag: two signals shared a pad |

## Verification
The ownership assertion assumes that in IDLE every live owner's select still names its pad. This holds only because every select write forces a rebuild, so the stimulus never changes select registers by any path other than the write port. The output-routing checks assume the bank is quiet during the rebuild. The bench therefore waits a full rebuild after the last select write before it samples `pad_out` or `pad_oe`. The restart check is the exception: it writes deliberately in the middle of a rebuild and samples before the restarted rebuild can finish. Input-side checks are sampled on the falling edge right after the write edge, because that path has no rebuild delay.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_CLEAR,
        SCAN_WALK,
        SCAN_COMMIT
    } scan_state_e;

    // Idle-high inputs: the I2C pairs and the UART receive lines.
    function automatic logic [127:0] idle_high_map();
        logic [127:0] m;
        m = '0;
        for (int i = 84; i <= 91; i++) m[i] = 1'b1;
        for (int u = 0; u < 4; u++) m[93 + 4 * u] = 1'b1;
        return m;
    endfunction

    localparam logic [127:0] IDLE_HIGH_MAP = idle_high_map();

endpackage

// File: rtl/xbar_sel_regs.sv
`timescale 1ns/1ps
module xbar_sel_regs #(
    parameter int NUM_SIG = 120,
    parameter int SEL_W   = 7,
    parameter int ADDR_W  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [SEL_W-1:0]           wdata,
    output logic [NUM_SIG*SEL_W-1:0]   sel_flat,
    output logic                       sel_wr
);

    assign sel_wr = we && (addr < ADDR_W'(NUM_SIG));

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sel
        logic [SEL_W-1:0] sel_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q <= '0;
            end else if (we && addr == ADDR_W'(g)) begin
                sel_q <= wdata;
            end
        end

        assign sel_flat[g*SEL_W +: SEL_W] = sel_q;

        // R2
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == ADDR_W'(g)) |=> (sel_flat[g*SEL_W +: SEL_W] == $past(wdata)));
    end

endmodule

// File: rtl/xbar_scan_fsm.sv
`timescale 1ns/1ps
module xbar_scan_fsm #(
    parameter int NUM_SIG = 120,
    parameter int NUM_PAD = 64,
    parameter int SEL_W   = 7,
    localparam int SIG_IDX_W = $clog2(NUM_SIG),
    localparam int PAD_IDX_W = $clog2(NUM_PAD)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_SIG*SEL_W-1:0]              sel_flat,
    input  logic                                  sel_wr,
    input  logic                                  flag_clr,
    output logic [NUM_PAD-1:0]                    own_v,
    output logic [NUM_PAD-1:0][SIG_IDX_W-1:0]     own_idx,
    output logic                                  conflict_flag
);
    import xbar_pkg::*;

    localparam logic [SIG_IDX_W-1:0] LAST_IDX = SIG_IDX_W'(NUM_SIG - 1);

    scan_state_e state_q, state_d;

    logic [SIG_IDX_W-1:0]                scan_idx;
    logic [SEL_W-1:0]                    sel_arr [NUM_SIG];
    logic [SEL_W-1:0]                    cur_sel;
    logic                                cur_hit;
    logic [PAD_IDX_W-1:0]                cur_pad;
    logic                                do_clear, do_step, do_commit;
    logic [NUM_PAD-1:0]                  shadow_v, live_v;
    logic [NUM_PAD-1:0][SIG_IDX_W-1:0]   shadow_own, live_own;
    logic                                walk_conf;
    logic                                conflict_q;

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_unpack
        assign sel_arr[g] = sel_flat[g*SEL_W +: SEL_W];
    end

    assign cur_sel = sel_arr[scan_idx];
    assign cur_hit = (cur_sel != '0) && (cur_sel <= SEL_W'(NUM_PAD));
    assign cur_pad = PAD_IDX_W'(cur_sel - 1'b1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE:   if (sel_wr) state_d = SCAN_CLEAR;
            SCAN_CLEAR:  state_d = sel_wr ? SCAN_CLEAR : SCAN_WALK;
            SCAN_WALK: begin
                if (sel_wr)                     state_d = SCAN_CLEAR;
                else if (scan_idx == LAST_IDX)  state_d = SCAN_COMMIT;
            end
            SCAN_COMMIT: state_d = sel_wr ? SCAN_CLEAR : SCAN_IDLE;
            default:     state_d = SCAN_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        do_clear  = 1'b0;
        do_step   = 1'b0;
        do_commit = 1'b0;
        unique case (state_q)
            SCAN_IDLE:   ;
            SCAN_CLEAR:  do_clear  = 1'b1;
            SCAN_WALK:   do_step   = !sel_wr;
            SCAN_COMMIT: do_commit = 1'b1;
            default:     ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_idx <= '0;
        end else if (do_clear) begin
            scan_idx <= '0;
        end else if (do_step && scan_idx != LAST_IDX) begin
            scan_idx <= scan_idx + 1'b1;
        end
    end

    // Shadow table: first claimant in ascending order keeps the pad
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_v   <= '0;
            shadow_own <= '0;
            walk_conf  <= 1'b0;
        end else if (do_clear) begin
            shadow_v   <= '0;
            walk_conf  <= 1'b0;
        end else if (do_step && cur_hit) begin
            if (shadow_v[cur_pad]) begin
                walk_conf <= 1'b1;
            end else begin
                shadow_v[cur_pad]   <= 1'b1;
                shadow_own[cur_pad] <= scan_idx;
            end
        end
    end

    // Live table, replaced as a whole
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_v   <= '0;
            live_own <= '0;
        end else if (do_commit) begin
            live_v   <= shadow_v;
            live_own <= shadow_own;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       conflict_q <= 1'b0;
        else if (do_commit && walk_conf)  conflict_q <= 1'b1;
        else if (flag_clr)                conflict_q <= 1'b0;
    end

    assign own_v         = live_v;
    assign own_idx       = live_own;
    assign conflict_flag = conflict_q;

    // R10
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SCAN_COMMIT) |=> $stable(live_v));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_q && !flag_clr) |=> conflict_q);

    // R4
    walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_WALK && scan_idx == LAST_IDX && !sel_wr) |=> (state_q == SCAN_COMMIT));

    for (genvar p = 0; p < NUM_PAD; p++) begin : g_own_chk
        // R6
        owner_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == SCAN_IDLE && live_v[p]) |-> (sel_arr[live_own[p]] == SEL_W'(p + 1)));
    end

endmodule

// File: rtl/xbar_pad_drive.sv
`timescale 1ns/1ps
module xbar_pad_drive #(
    parameter int NUM_SIG = 120,
    parameter int NUM_PAD = 64,
    localparam int SIG_IDX_W = $clog2(NUM_SIG)
) (
    input  logic [NUM_SIG-1:0]                 periph_out,
    input  logic [NUM_SIG-1:0]                 periph_oe,
    input  logic [NUM_PAD-1:0]                 own_v,
    input  logic [NUM_PAD-1:0][SIG_IDX_W-1:0]  own_idx,
    output logic [NUM_PAD-1:0]                 pad_out,
    output logic [NUM_PAD-1:0]                 pad_oe
);

    for (genvar p = 0; p < NUM_PAD; p++) begin : g_pad
        assign pad_out[p] = own_v[p] & periph_out[own_idx[p]];
        assign pad_oe[p]  = own_v[p] & periph_oe[own_idx[p]];
    end

endmodule

// File: rtl/xbar_in_route.sv
`timescale 1ns/1ps
module xbar_in_route #(
    parameter int               NUM_SIG   = 120,
    parameter int               NUM_PAD   = 64,
    parameter int               SEL_W     = 7,
    parameter logic [NUM_SIG-1:0] IDLE_HIGH = '0,
    localparam int              PAD_IDX_W = $clog2(NUM_PAD)
) (
    input  logic [NUM_SIG*SEL_W-1:0] sel_flat,
    input  logic [NUM_PAD-1:0]       pad_in,
    output logic [NUM_SIG-1:0]       periph_in
);

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
        logic [SEL_W-1:0]     s;
        logic                 hit;
        logic [PAD_IDX_W-1:0] pidx;

        assign s    = sel_flat[g*SEL_W +: SEL_W];
        assign hit  = (s != '0) && (s <= SEL_W'(NUM_PAD));
        assign pidx = PAD_IDX_W'(s - 1'b1);
        assign periph_in[g] = hit ? pad_in[pidx] : IDLE_HIGH[g];
    end

endmodule

// File: rtl/pad_route_xbar.sv
`timescale 1ns/1ps
module pad_route_xbar #(
    parameter int                 NUM_SIG   = 120,
    parameter int                 NUM_PAD   = 64,
    parameter int                 SEL_W     = 7,
    parameter logic [NUM_SIG-1:0] IDLE_HIGH = xbar_pkg::IDLE_HIGH_MAP[NUM_SIG-1:0],
    localparam int                ADDR_W    = $clog2(NUM_SIG + 1),
    localparam int                SIG_IDX_W = $clog2(NUM_SIG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [SEL_W-1:0]     cfg_wdata,
    input  logic [NUM_SIG-1:0]   periph_out,
    input  logic [NUM_SIG-1:0]   periph_oe,
    output logic [NUM_SIG-1:0]   periph_in,
    input  logic [NUM_PAD-1:0]   pad_in,
    output logic [NUM_PAD-1:0]   pad_out,
    output logic [NUM_PAD-1:0]   pad_oe,
    output logic                 conflict_flag
);

    logic [NUM_SIG*SEL_W-1:0]               sel_flat;
    logic                                   sel_wr;
    logic                                   flag_clr;
    logic [NUM_PAD-1:0]                     own_v;
    logic [NUM_PAD-1:0][SIG_IDX_W-1:0]      own_idx;

    assign flag_clr = cfg_we && (cfg_addr == ADDR_W'(NUM_SIG)) && cfg_wdata[0];

    xbar_sel_regs #(
        .NUM_SIG (NUM_SIG),
        .SEL_W   (SEL_W),
        .ADDR_W  (ADDR_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .sel_flat (sel_flat),
        .sel_wr   (sel_wr)
    );

    xbar_scan_fsm #(
        .NUM_SIG (NUM_SIG),
        .NUM_PAD (NUM_PAD),
        .SEL_W   (SEL_W)
    ) u_scan (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_flat      (sel_flat),
        .sel_wr        (sel_wr),
        .flag_clr      (flag_clr),
        .own_v         (own_v),
        .own_idx       (own_idx),
        .conflict_flag (conflict_flag)
    );

    xbar_pad_drive #(
        .NUM_SIG (NUM_SIG),
        .NUM_PAD (NUM_PAD)
    ) u_drive (
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .own_v      (own_v),
        .own_idx    (own_idx),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    xbar_in_route #(
        .NUM_SIG   (NUM_SIG),
        .NUM_PAD   (NUM_PAD),
        .SEL_W     (SEL_W),
        .IDLE_HIGH (IDLE_HIGH)
    ) u_in (
        .sel_flat  (sel_flat),
        .pad_in    (pad_in),
        .periph_in (periph_in)
    );

    for (genvar p = 0; p < NUM_PAD; p++) begin : g_pad_chk
        // R5
        free_pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !own_v[p] |-> (!pad_oe[p] && !pad_out[p]));
    end

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_in_chk
        // R9
        idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[g*SEL_W +: SEL_W] == '0) |-> (periph_in[g] == IDLE_HIGH[g]));
    end

endmodule

// File: tb/test_pad_route_xbar.sv
`timescale 1ns/1ps
module test_pad_route_xbar;

    localparam int NUM_SIG = 120;
    localparam int NUM_PAD = 64;
    localparam int SETTLE  = NUM_SIG + 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [6:0]         cfg_addr = '0;
    logic [6:0]         cfg_wdata = '0;
    logic [NUM_SIG-1:0] periph_out = '0;
    logic [NUM_SIG-1:0] periph_oe = '0;
    logic [NUM_SIG-1:0] periph_in;
    logic [NUM_PAD-1:0] pad_in = '0;
    logic [NUM_PAD-1:0] pad_out;
    logic [NUM_PAD-1:0] pad_oe;
    logic               conflict_flag;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    pad_route_xbar i_pad_route_xbar (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .periph_out    (periph_out),
        .periph_oe     (periph_oe),
        .periph_in     (periph_in),
        .pad_in        (pad_in),
        .pad_out       (pad_out),
        .pad_oe        (pad_oe),
        .conflict_flag (conflict_flag)
    );

    function automatic logic [NUM_SIG-1:0] exp_idle();
        logic [NUM_SIG-1:0] v;
        v = '0;
        for (int i = 84; i <= 91; i++) v[i] = 1'b1;
        v[93] = 1'b1; v[97] = 1'b1; v[101] = 1'b1; v[105] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        cfg_we = 1'b0;
        periph_out = '0;
        periph_oe = '0;
        pad_in = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 7'(addr);
        cfg_wdata = 7'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        pad_in = '1;
        #1;
        chk("R1", "pad_oe after reset", pad_oe, 0);
        chk("R1", "pad_out after reset", pad_out, 0);
        chk("R1", "conflict after reset", conflict_flag, 0);
        chk("R9", "idle inputs after reset", periph_in, exp_idle());
    endtask

    task automatic t_input();
        do_reset();
        wr(93, 20);
        chk("R2", "rx on pad 19 low", periph_in[93], 0);
        pad_in[19] = 1'b1; #1;
        chk("R2", "rx on pad 19 high", periph_in[93], 1);
        wr(0, 64);
        wr(1, 64);
        pad_in[63] = 1'b1; #1;
        chk("R8", "fan-out high", {periph_in[1], periph_in[0]}, 2'b11);
        pad_in[63] = 1'b0; #1;
        chk("R8", "fan-out low", {periph_in[1], periph_in[0]}, 2'b00);
    endtask

    task automatic t_boundary();
        do_reset();
        pad_in[0] = 1'b1;
        wr(2, 1);
        chk("R3", "select 1 reads pad 0", periph_in[2], 1);
        pad_in = '0; pad_in[63] = 1'b1;
        wr(2, 64);
        chk("R3", "select 64 reads pad 63", periph_in[2], 1);
        pad_in = '0;
        wr(84, 65);
        chk("R3", "select 65 unrouted idle", periph_in[84], 1);
        pad_in = '1;
        wr(3, 127);
        chk("R3", "select 127 unrouted idle", periph_in[3], 0);
        periph_oe = '1;
        settle();
        chk("R3", "only pad 63 enabled", pad_oe, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_output();
        do_reset();
        wr(5, 3);
        settle();
        periph_out[5] = 1'b1; periph_oe[5] = 1'b1; #1;
        chk("R4", "pad 2 enable", pad_oe, 64'h4);
        chk("R4", "pad 2 drives 1", pad_out, 64'h4);
        periph_out[5] = 1'b0; #1;
        chk("R4", "pad 2 drives 0", pad_out, 64'h0);
        chk("R5", "other pads off", pad_oe, 64'h4);
    endtask

    task automatic t_restart();
        do_reset();
        periph_oe = '1;
        wr(5, 3);
        settle();
        wr(5, 4);
        repeat (40) @(negedge clk);
        chk("R10", "old table mid rebuild", pad_oe, 64'h4);
        wr(7, 10);
        repeat (100) @(negedge clk);
        chk("R10", "old table after restart", pad_oe, 64'h4);
        settle();
        chk("R10", "new table committed", pad_oe, 64'h208);
    endtask

    task automatic t_conflict();
        do_reset();
        periph_oe = '1;
        periph_out[10] = 1'b1;
        wr(10, 7);
        wr(40, 7);
        settle();
        chk("R6", "lower index drives 1", pad_out, 64'h40);
        periph_out[10] = 1'b0; periph_out[40] = 1'b1; #1;
        chk("R6", "lower index drives 0", pad_out, 64'h0);
        chk("R7", "conflict set", conflict_flag, 1);
        wr(120, 0);
        chk("R7", "clear with bit0 low ignored", conflict_flag, 1);
        wr(120, 1);
        chk("R7", "conflict cleared", conflict_flag, 0);
        wr(10, 0);
        settle();
        chk("R6", "next signal takes pad", pad_out, 64'h40);
        chk("R7", "no conflict after unshare", conflict_flag, 0);
    endtask

    task automatic t_unroute();
        do_reset();
        periph_oe = '1;
        periph_out = '1;
        wr(5, 3);
        settle();
        chk("R4", "routed pad on", pad_oe, 64'h4);
        wr(5, 0);
        settle();
        chk("R5", "unrouted pad enable", pad_oe, 64'h0);
        chk("R5", "unrouted pad out", pad_out, 64'h0);
    endtask

    task automatic t_idle();
        do_reset();
        wr(84, 5);
        chk("R9", "routed i2c reads pad", periph_in[84], 0);
        wr(84, 0);
        chk("R9", "unrouted i2c idles high", periph_in[84], 1);
        chk("R9", "uart tx idles low", periph_in[92], 0);
    endtask

    initial begin
        t_reset();
        t_input();
        t_boundary();
        t_output();
        t_restart();
        t_conflict();
        t_unroute();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule